// File: doc/BRIEF.md
# Bus Cycle Timeout Watchdog

This block watches an asynchronous-style processor bus that uses an active-low address strobe and an active-low data acknowledge. When the address strobe falls, a cycle counter starts running on the bus clock. A responding device ends the bus cycle normally by pulling the acknowledge line low. If no acknowledge appears within a programmable number of clocks, the watchdog steps in so that the processor does not hang. In one mode it supplies a substitute acknowledge itself. In the other mode it pulls the bus-error line low.

Both shared lines are open-drain with external pull-ups. The block therefore drives only enables: a 1 on an enable means "pull the line low" and a 0 means "release it". The block never drives a line high. The limit is set with an input. A value of 8 is the usual quick setting. Systems with slow devices that insert wait states should use 31 or 63 so that those devices are not cut short. A one-clock timeout pulse lets a logger count bus cycles that nobody answered.

Top module: `bus_timeout_watchdog`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released, `dtack_pull`, `berr_pull` and `timeout` are all 0.
- R2: With `berr_mode`=0 and the strobe held low without any acknowledge, `dtack_pull` becomes 1 after exactly N rising edges of `clk` that sample `as_n` low. N is the effective limit. Before that point it stays 0.
- R3: With `berr_mode`=1 under the same conditions, `berr_pull` becomes 1 after N edges instead, and `dtack_pull` stays 0.
- R4: `dtack_pull` and `berr_pull` are never 1 together. A value of 1 on either output means "pull the line low" and 0 means "release it".
- R5: If `dtack_line_n` is sampled low during a bus cycle before the watchdog has fired, that cycle never times out. This holds even when the acknowledge arrives on the same edge that would have reached the limit.
- R6: Once asserted, the forced enable stays 1 while `as_n` stays low. It returns to 0 on the first rising edge that samples `as_n` high.
- R7: `timeout` is 1 for exactly one clock per expired bus cycle. It rises on the same edge as the forced enable.
- R8: When `as_n` is sampled high, the counter clears, so each bus cycle is timed from zero no matter what happened in the cycle before.
- R9: `limit` is a 6-bit unsigned count that is valid from 1 to 63. A value of 0 is treated as 1, and 63 gives a timeout after exactly 63 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| as_n | input | 1 | Address strobe, active low |
| dtack_line_n | input | 1 | Sensed level of the shared acknowledge line |
| berr_mode | input | 1 | 0: force acknowledge on expiry, 1: raise bus error |
| limit | input | LIMIT_W | Timeout limit in clocks (0 acts as 1) |
| dtack_pull | output | 1 | Enable to pull the acknowledge line low |
| berr_pull | output | 1 | Enable to pull the bus-error line low |
| timeout | output | 1 | One-clock pulse on each expiry |

## Verification
The hardest situation to reach is a tie at the limit: a native acknowledge arrives on exactly the edge at which the counter would expire. The block must treat that cycle as answered. The bench reaches it by releasing the external acknowledge low just before edge N of a cycle, so that both conditions are sampled on the same edge. The bench also models the wired line. It feeds the block's own forced pull back onto the sensed acknowledge, so the watchdog must ignore its own acknowledge after it has fired.

// File: rtl/bus_timeout_watchdog.sv
module bus_timeout_watchdog #(
  parameter int LIMIT_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               as_n,
  input  logic               dtack_line_n,
  input  logic               berr_mode,
  input  logic [LIMIT_W-1:0] limit,
  output logic               dtack_pull,
  output logic               berr_pull,
  output logic               timeout
);

  logic [LIMIT_W-1:0] cnt;
  logic [LIMIT_W-1:0] cnt_nxt;
  logic [LIMIT_W-1:0] eff_limit;
  logic               acked;
  logic               fired;
  logic               fire_err;

  assign cnt_nxt   = cnt + 1'b1;
  assign eff_limit = (limit == '0) ? LIMIT_W'(1) : limit;

  always_ff @(posedge clk) begin
    if (!rst_n || as_n) begin
      cnt      <= '0;
      acked    <= 1'b0;
      fired    <= 1'b0;
      fire_err <= 1'b0;
      timeout  <= 1'b0;
    end else begin
      timeout <= 1'b0;
      if (!fired) begin
        if (!dtack_line_n) begin
          acked <= 1'b1;
        end else if (!acked) begin
          cnt <= cnt_nxt;
          if (cnt_nxt == eff_limit) begin
            fired    <= 1'b1;
            fire_err <= berr_mode;
            timeout  <= 1'b1;
          end
        end
      end
    end
  end

  assign dtack_pull = fired & ~fire_err;
  assign berr_pull  = fired &  fire_err;

endmodule

// File: rtl/bus_timeout_watchdog_chk.sv
module bus_timeout_watchdog_chk (
  input logic clk,
  input logic rst_n,
  input logic as_n,
  input logic dtack_line_n,
  input logic dtack_pull,
  input logic berr_pull,
  input logic timeout
);

  a_r4_never_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(dtack_pull && berr_pull));

  a_r6_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> (!dtack_pull && !berr_pull));

  a_r6_hold_while_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((dtack_pull || berr_pull) && !as_n) |=> (dtack_pull || berr_pull));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);

  a_r7_pulse_with_pull: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> (dtack_pull || berr_pull));

  a_r5_native_ack_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_n && !dtack_line_n && !dtack_pull && !berr_pull) |=> !timeout);

endmodule

bind bus_timeout_watchdog bus_timeout_watchdog_chk i_chk (
  .clk(clk), .rst_n(rst_n), .as_n(as_n), .dtack_line_n(dtack_line_n),
  .dtack_pull(dtack_pull), .berr_pull(berr_pull), .timeout(timeout)
);

// File: tb/test_bus_timeout_watchdog.sv
`timescale 1ns/1ps
module test_bus_timeout_watchdog;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       as_n = 1'b1;
  logic       ext_ack_n = 1'b1;
  logic       berr_mode = 1'b0;
  logic [5:0] limit = 6'd8;
  logic       dtack_line_n;
  logic       dtack_pull, berr_pull, timeout;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_cnt = 0;
  bit m_ack = 0, m_fired = 0, m_err = 0, m_to = 0;

  always #2 clk = ~clk;

  assign dtack_line_n = ext_ack_n & ~dtack_pull;

  bus_timeout_watchdog i_bus_timeout_watchdog (
    .clk(clk), .rst_n(rst_n), .as_n(as_n), .dtack_line_n(dtack_line_n),
    .berr_mode(berr_mode), .limit(limit), .dtack_pull(dtack_pull),
    .berr_pull(berr_pull), .timeout(timeout)
  );

  task automatic compare(string req);
    logic [2:0] exp_v, act_v;
    exp_v = {m_fired & ~m_err, m_fired & m_err, m_to};
    act_v = {dtack_pull, berr_pull, timeout};
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s t=%0t {dtack_pull,berr_pull,timeout} actual=%b expected=%b",
               req, $time, act_v, exp_v);
    end
  endtask

  task automatic step(string req);
    int eff;
    eff = (limit == 0) ? 1 : int'(limit);
    if (!rst_n || as_n) begin
      m_cnt = 0; m_ack = 0; m_fired = 0; m_err = 0; m_to = 0;
    end else begin
      m_to = 0;
      if (!m_fired) begin
        if (!ext_ack_n) m_ack = 1;
        else if (!m_ack) begin
          m_cnt++;
          if (m_cnt == eff) begin m_fired = 1; m_err = berr_mode; m_to = 1; end
        end
      end
    end
    @(posedge clk); #1;
    compare(req);
  endtask

  task automatic bus_cycle(string req, bit mode, int lim, int ack_at, int len);
    berr_mode = mode; limit = 6'(lim); as_n = 1'b0; ext_ack_n = 1'b1;
    for (int e = 1; e <= len; e++) begin
      if (ack_at == e) ext_ack_n = 1'b0;
      step(req);
    end
    as_n = 1'b1; ext_ack_n = 1'b1;
    step(req);
    step(req);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step("R1"); step("R1");
    rst_n = 1'b1;
    step("R1");
  endtask

  task automatic t_ignore_mode();
    bus_cycle("R2", 1'b0, 8, 0, 12);
  endtask

  task automatic t_error_mode();
    bus_cycle("R3", 1'b1, 5, 0, 9);
    bus_cycle("R4", 1'b1, 2, 0, 4);
  endtask

  task automatic t_native_ack();
    bus_cycle("R5", 1'b0, 8, 3, 14);
    bus_cycle("R5", 1'b1, 6, 6, 10);
    bus_cycle("R5", 1'b0, 6, 7, 10);
  endtask

  task automatic t_hold_release();
    bus_cycle("R6", 1'b0, 3, 0, 20);
    bus_cycle("R7", 1'b1, 4, 0, 8);
  endtask

  task automatic t_independent();
    bus_cycle("R8", 1'b0, 10, 0, 7);
    bus_cycle("R8", 1'b0, 10, 0, 12);
    bus_cycle("R8", 1'b1, 4, 2, 6);
    bus_cycle("R8", 1'b1, 4, 0, 6);
  endtask

  task automatic t_limit_range();
    bus_cycle("R9", 1'b0, 0, 0, 3);
    bus_cycle("R9", 1'b1, 1, 0, 3);
    bus_cycle("R9", 1'b0, 63, 0, 66);
    bus_cycle("R9", 1'b1, 31, 0, 33);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1;
    t_reset();
    t_ignore_mode();
    t_error_mode();
    t_native_ack();
    t_hold_release();
    t_independent();
    t_limit_range();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end
endmodule